// File: doc/BRIEF.md
# Fast Ethernet Transmit Line Encoder

This block turns a stream of 4-bit transmit nibbles into the three-level symbol stream a 100 Mb/s twisted-pair transmitter puts on the wire. It runs on one 125 MHz clock. Once every five cycles it pulses `nibbleStrobe`, and it captures the nibble inputs at the next rising edge, which gives the 25 MHz nibble rate. Each captured slot picks a 5-bit code group: an idle filler, a frame delimiter, a data group or an error group. The group is sent one bit per cycle and whitened with an 11-bit maximal-length LFSR keystream. The result is NRZI coded, and each NRZI transition steps a three-level MLT-3 line state.

A MAC-side source drives `txEnable`, `txError` and `txData`, holding them steady across each strobe. It reads `lineSym` as a signed 2-bit symbol per clock, ready for an analog driver. The keystream can be switched off with `scrambleOn` for a plain, unwhitened line.

Top module: `fe_tx_line_encoder`

## Requirements
- R1: While `rstN` is low, `lineSym` is 0 and `nibbleStrobe` is low. The first group sent after reset is the idle group 11111.
- R2: `nibbleStrobe` is high for one cycle in every five, first in the fifth cycle after reset. Inputs are captured at the edge that ends that cycle, and the chosen group is sent in the next five cycles. Groups are written in send order, so the leftmost bit goes first.
- R3: A captured slot with `txEnable` low, outside a frame, sends the idle group 11111.
- R4: The first slot with `txEnable` high sends J (11000), and the following slot sends K (10001). The nibble data in both slots is ignored.
- R5: Later enabled slots send the data group for `txData`. The groups for 0..F are 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100 and 11101.
- R6: An enabled slot inside a frame with `txError` high sends H (00100) in place of the data group.
- R7: The first slot inside a frame with `txEnable` low sends T (01101), and the next slot sends R (00111) whatever its inputs are. If `txEnable` is high in the slot after R, a new frame starts at once with J.
- R8: With `scrambleOn` high, each bit is XORed with a keystream bit f = s[10] XOR s[8]. Every cycle, s shifts left with f entering bit 0. s is reset to all ones, never becomes zero, and repeats after 2047 cycles.
- R9: With `scrambleOn` low, bits go unwhitened onto the line, so idle shows a line transition on every cycle.
- R10: A 1 at the NRZI stage toggles NRZI. Each toggle steps the line through 0, +1, 0, -1 cyclically (encoded 00, 01, 00, 11), and otherwise the level holds. The bit sent in a cycle reaches `lineSym` after the following clock edge.
- R11: `lineSym` never takes the value 10 and never moves straight between +1 and -1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 125 MHz symbol clock |
| rstN | input | 1 | Active-low synchronous reset |
| scrambleOn | input | 1 | Enables the keystream whitening |
| txEnable | input | 1 | Frame enable for the captured slot |
| txError | input | 1 | Marks the captured slot as an error |
| txData | input | 4 | Nibble for the captured slot |
| nibbleStrobe | output | 1 | High in the cycle whose closing edge captures the inputs |
| lineSym | output | 2 | Signed line symbol: 01 = +1, 00 = 0, 11 = -1 |

## Verification
On every cycle, the assertions check the strobe spacing, the legality of the line symbol, the ban on direct swings between +1 and -1, the held level when there is no NRZI transition, and the nonzero LFSR. Only the bench scenarios can show that the right code groups come out in the right order. The bench recovers them from the line by decoding the level changes and removing its own keystream, then compares them group by group against a frame model. That covers the full data table, the ignored J/K and R slots, error groups, one-slot frames, back-to-back frames, more than one full keystream period, and the unscrambled mode.

// File: rtl/fe_line_pkg.sv
package fe_line_pkg;

  localparam int GROUP_BITS = 5;
  localparam int PHASE_W    = $clog2(GROUP_BITS);

  typedef enum logic [2:0] {
    SEL_IDLE, SEL_J, SEL_K, SEL_DATA, SEL_T, SEL_R, SEL_H
  } codeSelT;

  typedef enum logic [2:0] {
    FR_IDLE, FR_J, FR_BODY, FR_T, FR_R
  } frameStateT;

  typedef struct packed {
    logic               load;
    codeSelT            sel;
    logic [3:0]         nibble;
    logic [PHASE_W-1:0] bitPos;
  } ctrlStrobeT;

  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [1:0] SYM_POS  = 2'b01;
  localparam logic [1:0] SYM_NEG  = 2'b11;

  // Data groups, leftmost bit is sent first
  function automatic logic [GROUP_BITS-1:0] dataGroup(input logic [3:0] n);
    logic [GROUP_BITS-1:0] g;
    case (n)
      4'h0: g = 5'b11110;
      4'h1: g = 5'b01001;
      4'h2: g = 5'b10100;
      4'h3: g = 5'b10101;
      4'h4: g = 5'b01010;
      4'h5: g = 5'b01011;
      4'h6: g = 5'b01110;
      4'h7: g = 5'b01111;
      4'h8: g = 5'b10010;
      4'h9: g = 5'b10011;
      4'hA: g = 5'b10110;
      4'hB: g = 5'b10111;
      4'hC: g = 5'b11010;
      4'hD: g = 5'b11011;
      4'hE: g = 5'b11100;
      default: g = 5'b11101;
    endcase
    return g;
  endfunction

  function automatic logic [GROUP_BITS-1:0] groupCode(input codeSelT sel,
                                                      input logic [3:0] n);
    logic [GROUP_BITS-1:0] g;
    case (sel)
      SEL_J:    g = 5'b11000;
      SEL_K:    g = 5'b10001;
      SEL_DATA: g = dataGroup(n);
      SEL_T:    g = 5'b01101;
      SEL_R:    g = 5'b00111;
      SEL_H:    g = 5'b00100;
      default:  g = 5'b11111;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/fe_tx_ctrl.sv
module fe_tx_ctrl
  import fe_line_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic       txError,
  input  logic [3:0] txData,
  output logic       nibbleStrobe,
  output ctrlStrobeT strobeOut
);

  localparam logic [PHASE_W-1:0] LAST_POS = PHASE_W'(GROUP_BITS - 1);

  logic [PHASE_W-1:0] phaseQ;
  frameStateT         stateQ, stateNext;
  codeSelT            selNext;
  logic               lastBit;

  assign lastBit = (phaseQ == LAST_POS);

  always_comb begin
    stateNext = stateQ;
    selNext   = SEL_IDLE;
    case (stateQ)
      FR_IDLE: begin
        if (txEnable) begin
          selNext   = SEL_J;
          stateNext = FR_J;
        end
      end
      FR_J: begin
        selNext   = SEL_K;
        stateNext = FR_BODY;
      end
      FR_BODY: begin
        if (txEnable) begin
          selNext = txError ? SEL_H : SEL_DATA;
        end else begin
          selNext   = SEL_T;
          stateNext = FR_T;
        end
      end
      FR_T: begin
        selNext   = SEL_R;
        stateNext = FR_R;
      end
      FR_R: begin
        if (txEnable) begin
          selNext   = SEL_J;
          stateNext = FR_J;
        end else begin
          stateNext = FR_IDLE;
        end
      end
      default: stateNext = FR_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= '0;
      stateQ <= FR_IDLE;
    end else begin
      phaseQ <= lastBit ? '0 : phaseQ + 1'b1;
      if (lastBit) stateQ <= stateNext;
    end
  end

  assign nibbleStrobe     = lastBit & rstN;
  assign strobeOut.load   = lastBit;
  assign strobeOut.sel    = selNext;
  assign strobeOut.nibble = txData;
  assign strobeOut.bitPos = phaseQ;

  // R2: a strobe is followed by the first bit position of a fresh group
  assert_group_restart_R2: assert property (@(posedge clk) disable iff (!rstN)
    nibbleStrobe |=> (strobeOut.bitPos == '0));

  // R2: strobes never come on adjacent cycles
  assert_strobe_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    nibbleStrobe |=> !nibbleStrobe);

endmodule

// File: rtl/fe_tx_scrambler.sv
module fe_tx_scrambler #(
  parameter int                  LFSR_LEN  = 11,
  parameter int                  LFSR_TAP  = 9,
  parameter logic [LFSR_LEN-1:0] LFSR_SEED = '1
) (
  input  logic clk,
  input  logic rstN,
  input  logic enable,
  input  logic plainBit,
  output logic scrBit
);

  logic [LFSR_LEN-1:0] lfsrQ;
  logic                keyBit;

  generate
    if (LFSR_SEED == '0) begin : gen_bad_seed
      $error("scrambler seed must be nonzero");
    end
  endgenerate

  assign keyBit = lfsrQ[LFSR_LEN-1] ^ lfsrQ[LFSR_TAP-1];
  assign scrBit = plainBit ^ (enable & keyBit);

  always_ff @(posedge clk) begin
    if (!rstN) lfsrQ <= LFSR_SEED;
    else       lfsrQ <= {lfsrQ[LFSR_LEN-2:0], keyBit};
  end

  // R8: the register can never lock up in the all-zero state
  assert_lfsr_nonzero_R8: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

endmodule

// File: rtl/fe_tx_mlt3.sv
module fe_tx_mlt3
  import fe_line_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       nrziNow,
  input  logic       nrziNext,
  output logic [1:0] lineSym
);

  logic [1:0] phaseQ, phaseNext;
  logic [1:0] symQ, symNext;
  logic       toggle;

  assign toggle    = nrziNow ^ nrziNext;
  assign phaseNext = toggle ? phaseQ + 2'd1 : phaseQ;

  always_comb begin
    case (phaseNext)
      2'd1:    symNext = SYM_POS;
      2'd3:    symNext = SYM_NEG;
      default: symNext = SYM_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= 2'd0;
      symQ   <= SYM_ZERO;
    end else begin
      phaseQ <= phaseNext;
      symQ   <= symNext;
    end
  end

  assign lineSym = symQ;

  // R10: without an NRZI transition the line level holds
  assert_hold_level_R10: assert property (@(posedge clk) disable iff (!rstN)
    (nrziNow == nrziNext) |=> $stable(lineSym));

  // R11: only the three legal codes appear
  assert_sym_legal_R11: assert property (@(posedge clk) disable iff (!rstN)
    lineSym != 2'b10);

  // R11: no direct swing from +1 to -1
  assert_no_swing_up_R11: assert property (@(posedge clk) disable iff (!rstN)
    (lineSym == SYM_POS) |=> (lineSym != SYM_NEG));

  // R11: no direct swing from -1 to +1
  assert_no_swing_down_R11: assert property (@(posedge clk) disable iff (!rstN)
    (lineSym == SYM_NEG) |=> (lineSym != SYM_POS));

endmodule

// File: rtl/fe_tx_datapath.sv
module fe_tx_datapath
  import fe_line_pkg::*;
#(
  parameter int                  LFSR_LEN  = 11,
  parameter int                  LFSR_TAP  = 9,
  parameter logic [LFSR_LEN-1:0] LFSR_SEED = '1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scrambleOn,
  input  ctrlStrobeT ctrlIn,
  output logic [1:0] lineSym
);

  logic [GROUP_BITS-1:0] groupQ;
  logic                  plainBit;
  logic                  scrBit;
  logic                  nrziQ;
  logic                  nrziNext;

  always_ff @(posedge clk) begin
    if (!rstN) groupQ <= '1;
    else if (ctrlIn.load) groupQ <= groupCode(ctrlIn.sel, ctrlIn.nibble);
  end

  // Serializer: leftmost group bit leaves first
  always_comb begin
    plainBit = 1'b0;
    for (int i = 0; i < GROUP_BITS; i++) begin
      if (ctrlIn.bitPos == PHASE_W'(i)) plainBit = groupQ[GROUP_BITS-1-i];
    end
  end

  fe_tx_scrambler #(
    .LFSR_LEN (LFSR_LEN),
    .LFSR_TAP (LFSR_TAP),
    .LFSR_SEED(LFSR_SEED)
  ) uScrambler (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (scrambleOn),
    .plainBit(plainBit),
    .scrBit  (scrBit)
  );

  assign nrziNext = nrziQ ^ scrBit;

  always_ff @(posedge clk) begin
    if (!rstN) nrziQ <= 1'b0;
    else       nrziQ <= nrziNext;
  end

  fe_tx_mlt3 uMlt3 (
    .clk     (clk),
    .rstN    (rstN),
    .nrziNow (nrziQ),
    .nrziNext(nrziNext),
    .lineSym (lineSym)
  );

endmodule

// File: rtl/fe_tx_line_encoder.sv
module fe_tx_line_encoder
  import fe_line_pkg::*;
#(
  parameter int                  LFSR_LEN  = 11,
  parameter int                  LFSR_TAP  = 9,
  parameter logic [LFSR_LEN-1:0] LFSR_SEED = '1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       scrambleOn,
  input  logic       txEnable,
  input  logic       txError,
  input  logic [3:0] txData,
  output logic       nibbleStrobe,
  output logic [1:0] lineSym
);

  ctrlStrobeT ctrlBus;

  fe_tx_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .txEnable    (txEnable),
    .txError     (txError),
    .txData      (txData),
    .nibbleStrobe(nibbleStrobe),
    .strobeOut   (ctrlBus)
  );

  fe_tx_datapath #(
    .LFSR_LEN (LFSR_LEN),
    .LFSR_TAP (LFSR_TAP),
    .LFSR_SEED(LFSR_SEED)
  ) uDatapath (
    .clk       (clk),
    .rstN      (rstN),
    .scrambleOn(scrambleOn),
    .ctrlIn    (ctrlBus),
    .lineSym   (lineSym)
  );

endmodule

// File: tb/tb_fe_tx_line_encoder.sv
module tb_fe_tx_line_encoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       scrambleOn = 1'b1;
  logic       txEnable = 1'b0;
  logic       txError = 1'b0;
  logic [3:0] txData = 4'h0;
  logic       nibbleStrobe;
  logic [1:0] lineSym;

  fe_tx_line_encoder dut (
    .clk(clk), .rstN(rstN), .scrambleOn(scrambleOn),
    .txEnable(txEnable), .txError(txError), .txData(txData),
    .nibbleStrobe(nibbleStrobe), .lineSym(lineSym)
  );

  always #4 clk = ~clk;

  typedef struct { bit en; bit er; logic [3:0] d; } slotT;
  typedef struct { logic [4:0] code; string tag; } expT;

  int         checks = 0;
  int         errors = 0;
  bit         finished = 0;
  slotT       plan[$];
  expT        expQ[$];
  logic [10:0] mLfsr;
  logic [1:0] prevSym;
  logic [1:0] mPhase;
  int         bitIdx;
  logic [4:0] asmGroup;
  int         mState;
  string      modeTag;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] dataCode(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110;  4'h1: return 5'b01001;
      4'h2: return 5'b10100;  4'h3: return 5'b10101;
      4'h4: return 5'b01010;  4'h5: return 5'b01011;
      4'h6: return 5'b01110;  4'h7: return 5'b01111;
      4'h8: return 5'b10010;  4'h9: return 5'b10011;
      4'hA: return 5'b10110;  4'hB: return 5'b10111;
      4'hC: return 5'b11010;  4'hD: return 5'b11011;
      4'hE: return 5'b11100;  default: return 5'b11101;
    endcase
  endfunction

  function automatic logic [1:0] levelOf(input logic [1:0] p);
    case (p)
      2'd1: return 2'b01;
      2'd3: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic pushExp(input logic [4:0] c, input string t);
    expT e;
    e.code = c;
    e.tag  = t;
    expQ.push_back(e);
  endtask

  // Frame model: choose the group for the slot captured now
  task automatic modelSlot(input slotT s);
    case (mState)
      0: if (s.en) begin pushExp(5'b11000, "R4"); mState = 1; end
         else pushExp(5'b11111, "R3");
      1: begin pushExp(5'b10001, "R4"); mState = 2; end
      2: if (s.en) begin
           if (s.er) pushExp(5'b00100, "R6");
           else      pushExp(dataCode(s.d), "R5");
         end else begin
           pushExp(5'b01101, "R7"); mState = 3;
         end
      3: begin pushExp(5'b00111, "R7"); mState = 4; end
      default: if (s.en) begin pushExp(5'b11000, "R7"); mState = 1; end
               else begin pushExp(5'b11111, "R3"); mState = 0; end
    endcase
  endtask

  // One negedge: decode the last line cycle, then drive the next slot
  task automatic step();
    logic [1:0] sym;
    bit         changed;
    logic       key;
    logic       plain;
    slotT       s;
    expT        e;
    sym = lineSym;
    changed = (sym != prevSym);
    check(sym != 2'b10, "R11 legal code", sym, 0);
    check(!((prevSym == 2'b01 && sym == 2'b11) || (prevSym == 2'b11 && sym == 2'b01)),
          "R11 swing", sym, prevSym);
    if (changed) mPhase = mPhase + 2'd1;
    check(sym == levelOf(mPhase), "R10 level sequence", sym, levelOf(mPhase));
    prevSym = sym;
    key   = mLfsr[10] ^ mLfsr[8];
    mLfsr = {mLfsr[9:0], key};
    plain = changed ^ (scrambleOn & key);
    asmGroup = {asmGroup[3:0], plain};
    bitIdx++;
    if (bitIdx == 5) begin
      bitIdx = 0;
      if (expQ.size() == 0) begin
        check(1'b0, "R2 group without expectation", asmGroup, 0);
      end else begin
        e = expQ.pop_front();
        check(asmGroup == e.code, {e.tag, " group ", modeTag}, asmGroup, e.code);
      end
    end
    check(nibbleStrobe == (bitIdx == 4), "R2 strobe timing", nibbleStrobe, bitIdx == 4);
    if (nibbleStrobe) begin
      if (plan.size() > 0) s = plan.pop_front();
      else begin s.en = 0; s.er = 0; s.d = 4'h0; end
      txEnable = s.en;
      txError  = s.er;
      txData   = s.d;
      modelSlot(s);
    end
  endtask

  task automatic doReset(input bit scr);
    @(negedge clk);
    rstN = 1'b0;
    scrambleOn = scr;
    txEnable = 0; txError = 0; txData = 0;
    repeat (3) @(negedge clk);
    check(lineSym == 2'b00, "R1 reset symbol", lineSym, 0);
    check(nibbleStrobe == 1'b0, "R1 reset strobe", nibbleStrobe, 0);
    plan.delete();
    expQ.delete();
    mLfsr = 11'h7FF; prevSym = 2'b00; mPhase = 2'd0;
    bitIdx = 0; asmGroup = 5'd0; mState = 0;
    pushExp(5'b11111, "R1");
    rstN = 1'b1;
  endtask

  task automatic runCycles(input int n);
    repeat (n) begin
      @(negedge clk);
      step();
    end
  endtask

  task automatic addSlot(input bit en, input bit er, input logic [3:0] d);
    slotT s;
    s.en = en; s.er = er; s.d = d;
    plan.push_back(s);
  endtask

  // Frame set: all data values, ignored J/K/R slots, error, short and back-to-back frames
  task automatic loadFrames();
    addSlot(0, 0, 4'h0);
    addSlot(1, 1, 4'hA);               // R4: J slot, data and error ignored
    addSlot(1, 0, 4'h5);               // R4: K slot, data ignored
    for (int v = 0; v < 16; v++) addSlot(1, 0, 4'(v));  // R5 sweep
    addSlot(0, 0, 4'h0);               // R7: T
    addSlot(0, 1, 4'h9);               // R7: R slot, inputs ignored
    addSlot(0, 0, 4'h0);
    addSlot(1, 0, 4'h1);               // one-slot frame: J K T R
    addSlot(0, 0, 4'h0);
    addSlot(0, 0, 4'h0);
    addSlot(0, 0, 4'h0);
    addSlot(1, 0, 4'h0); addSlot(1, 0, 4'h0);
    addSlot(1, 0, 4'h7); addSlot(1, 1, 4'h7); addSlot(1, 0, 4'hC);  // R6
    addSlot(0, 0, 4'h0);
    addSlot(1, 0, 4'h3);               // R7: enable during R slot
    addSlot(1, 0, 4'h2);               // R7: new J right after R
    addSlot(1, 0, 4'h0);
    addSlot(1, 0, 4'hF);
    addSlot(0, 0, 4'h0);
  endtask

  initial begin
    // R8: long idle run spans more than one keystream period
    modeTag = "R8";
    doReset(1'b1);
    runCycles(2200);
    loadFrames();
    runCycles(plan.size() * 5 + 40);
    // R9: unscrambled line
    modeTag = "R9";
    doReset(1'b0);
    runCycles(60);
    loadFrames();
    runCycles(plan.size() * 5 + 40);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule